// File: doc/BRIEF.md
# Parallel Bus Address Recognizer

This block watches an eight-bit, IEEE-488-style parallel bus and decides whether the local device is being addressed. The bus pins are active-low. They are inverted once at the input boundary, so all logic inside the block is active-high. A five-bit address from local switches is compared with the five low data bits to produce a my-address indication.

Each byte is taken on the first cycle in which the data-valid strobe is seen asserted. The byte counts only if attention is asserted and end-or-identify is not. Data bits 7 and 6 select a group. The listen group sets or clears a listener-addressed flag, and the talk group sets or clears a talker-addressed flag. A listen-only strap keeps the talker flag cleared.

The bus here is strobe-based, not valid/ready. The block never applies back-pressure: it has no ready output, and pacing is left to the handshake logic outside it.

Top module: `bus_addr_recognizer`

## Requirements
- R1: All bus inputs (`bus_d_n`, `atn_n`, `eoi_n`, `dav_n`) are active-low. A pin at 0 means asserted or a data one. Data bit k of the bus (k = 1..8) is `bus_d_n[k-1]`.
- R2: `my_addr` is combinational. It is 1 exactly when ATN is asserted and inverted data bits [4:0] equal `addr_sw`.
- R3: A byte is accepted only in the first clock cycle in which DAV is seen asserted after having been deasserted. The flags change at that clock edge. Holding DAV asserted does not sample the byte again, even if the data changes.
- R4: An accepted byte whose inverted bits [6:5] are 2'b01 and whose bits [4:0] equal `addr_sw` sets `listen_flag`. This applies only when bits [4:0] are not all ones.
- R5: An accepted byte with bits [6:5] = 2'b01 and bits [4:0] = 5'b11111 (the unlisten byte) clears `listen_flag`. This takes priority over any address match.
- R6: An accepted byte with bits [6:5] = 2'b10 and bits [4:0] equal to `addr_sw` sets `talk_flag` when `listen_only` is 0.
- R7: An accepted byte with bits [6:5] = 2'b10 and any other address clears `talk_flag`. Talk-group bytes never change `listen_flag`, and listen-group bytes never change `talk_flag`.
- R8: While `listen_only` is 1, `talk_flag` is cleared at the next clock edge and stays 0, whatever the bytes carry.
- R9: A byte presented while EOI is asserted, or while ATN is deasserted, changes neither flag.
- R10: A synchronous reset (`rst` high at a clock edge) clears both flags.
- R11: Accepted bytes with bits [6:5] equal to 2'b00 or 2'b11 leave both flags unchanged. Bit [7] (bus bit 8) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_d_n | input | 8 | Bus data lines, active low |
| atn_n | input | 1 | Attention line, active low |
| eoi_n | input | 1 | End-or-identify line, active low |
| dav_n | input | 1 | Data-valid strobe, active low |
| addr_sw | input | 5 | Local address switches, active high |
| listen_only | input | 1 | Listen-only strap, disables talker addressing |
| my_addr | output | 1 | Bus low five bits match the switches under ATN |
| listen_flag | output | 1 | Device is addressed to listen |
| talk_flag | output | 1 | Device is addressed to talk |

## Verification
The hardest case to reach from the ports is DAV held asserted while the data lines change to a byte that would alter a flag. The change must have no effect. The bench accepts a listen address and keeps the strobe low. It then moves the bus to the unlisten byte for several cycles and checks that the listener flag survives.

Two further cases are driven directly. In one, the switches are set to all ones, so the device's own listen address coincides with unlisten. In the other, the listen-only strap is raised while the talker flag is already set.

// File: rtl/bar_pkg.sv
package bar_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam logic [1:0] GRP_LISTEN = 2'b01;
  localparam logic [1:0] GRP_TALK   = 2'b10;

  typedef struct packed {
    logic match;
    logic lgrp;
    logic tgrp;
    logic ones;
  } cmd_t;
endpackage

// File: rtl/bar_input_stage.sv
module bar_input_stage #(
  parameter int DATA_W = bar_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] bus_d_n,
  input  logic              atn_n,
  input  logic              eoi_n,
  input  logic              dav_n,
  output logic [DATA_W-1:0] data,
  output logic              atn,
  output logic              accept
);
  logic dav, dav_q, eoi;

  assign data = ~bus_d_n;
  assign atn  = ~atn_n;
  assign eoi  = ~eoi_n;
  assign dav  = ~dav_n;

  // Start as if DAV was already seen, so a strobe held through reset is not taken.
  always_ff @(posedge clk) begin
    if (rst) dav_q <= 1'b1;
    else     dav_q <= dav;
  end

  assign accept = dav & ~dav_q & atn & ~eoi;

  // R3
  strobe_once_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> !accept);
endmodule

// File: rtl/bar_cmd_decode.sv
module bar_cmd_decode #(
  parameter int DATA_W = bar_pkg::DATA_W,
  parameter int ADDR_W = bar_pkg::ADDR_W
) (
  input  logic [DATA_W-1:0] data,
  input  logic [ADDR_W-1:0] addr_sw,
  output bar_pkg::cmd_t     cmd
);
  localparam int GRP_LSB = ADDR_W;
  logic [1:0] grp;

  assign grp       = data[GRP_LSB+1:GRP_LSB];
  assign cmd.match = (data[ADDR_W-1:0] == addr_sw);
  assign cmd.ones  = &data[ADDR_W-1:0];
  assign cmd.lgrp  = (grp == bar_pkg::GRP_LISTEN);
  assign cmd.tgrp  = (grp == bar_pkg::GRP_TALK);
endmodule

// File: rtl/bar_state_flags.sv
module bar_state_flags (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  bar_pkg::cmd_t cmd,
  input  logic          listen_only,
  output logic          listen_flag,
  output logic          talk_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      listen_flag <= 1'b0;
    end else if (accept && cmd.lgrp) begin
      if (cmd.ones)       listen_flag <= 1'b0;
      else if (cmd.match) listen_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || listen_only) talk_flag <= 1'b0;
    else if (accept && cmd.tgrp) talk_flag <= cmd.match;
  end

  // R5
  unlisten_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && cmd.lgrp && cmd.ones) |=> !listen_flag);
  // R8
  talk_off_chk: assert property (@(posedge clk) disable iff (rst)
    listen_only |=> !talk_flag);
  // R3
  listen_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(listen_flag));
  // R7
  talk_iso_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !cmd.tgrp && !listen_only) |=> $stable(talk_flag));
endmodule

// File: rtl/bus_addr_recognizer.sv
module bus_addr_recognizer #(
  parameter int DATA_W = bar_pkg::DATA_W,
  parameter int ADDR_W = bar_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] bus_d_n,
  input  logic              atn_n,
  input  logic              eoi_n,
  input  logic              dav_n,
  input  logic [ADDR_W-1:0] addr_sw,
  input  logic              listen_only,
  output logic              my_addr,
  output logic              listen_flag,
  output logic              talk_flag
);
  logic [DATA_W-1:0] data;
  logic              atn, accept;
  bar_pkg::cmd_t     cmd;

  bar_input_stage #(.DATA_W(DATA_W)) u_in (
    .clk(clk), .rst(rst), .bus_d_n(bus_d_n), .atn_n(atn_n),
    .eoi_n(eoi_n), .dav_n(dav_n), .data(data), .atn(atn), .accept(accept));

  bar_cmd_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
    .data(data), .addr_sw(addr_sw), .cmd(cmd));

  bar_state_flags u_flags (
    .clk(clk), .rst(rst), .accept(accept), .cmd(cmd),
    .listen_only(listen_only), .listen_flag(listen_flag), .talk_flag(talk_flag));

  assign my_addr = atn & cmd.match;

  // R2
  my_addr_atn_chk: assert property (@(posedge clk) disable iff (rst)
    my_addr |-> !atn_n);
  // R9
  eoi_block_chk: assert property (@(posedge clk) disable iff (rst)
    !eoi_n |=> ($stable(listen_flag) && (listen_only || $stable(talk_flag))));
endmodule

// File: tb/test_bus_addr_recognizer.sv
module test_bus_addr_recognizer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_d_n = 8'hFF;
  logic       atn_n = 1'b1, eoi_n = 1'b1, dav_n = 1'b1;
  logic [4:0] addr_sw = 5'b01101;
  logic       listen_only = 1'b0;
  logic       my_addr, listen_flag, talk_flag;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  bus_addr_recognizer i_bus_addr_recognizer (
    .clk(clk), .rst(rst), .bus_d_n(bus_d_n), .atn_n(atn_n), .eoi_n(eoi_n),
    .dav_n(dav_n), .addr_sw(addr_sw), .listen_only(listen_only),
    .my_addr(my_addr), .listen_flag(listen_flag), .talk_flag(talk_flag));

  // Vector layout: {data byte (positive logic), expected listen, expected talk}.
  localparam int NV = 11;
  localparam logic [9:0] VEC [NV] = '{
    {8'h2D, 1'b1, 1'b0},  // R4 listen to own address
    {8'h4D, 1'b1, 1'b1},  // R6 talk to own address
    {8'h3F, 1'b0, 1'b1},  // R5 unlisten
    {8'h43, 1'b0, 1'b0},  // R7 another device's talk address
    {8'h2D, 1'b1, 1'b0},  // R4
    {8'h0D, 1'b1, 1'b0},  // R11 group 00
    {8'h6D, 1'b1, 1'b0},  // R11 group 11
    {8'hCD, 1'b1, 1'b1},  // R11 bit 8 ignored, R6
    {8'h23, 1'b1, 1'b1},  // R7 other listen address, no change
    {8'h5F, 1'b1, 1'b0},  // R7 untalk
    {8'h4D, 1'b1, 1'b1}   // R6
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic atn, input logic eoi);
    @(negedge clk);
    bus_d_n = ~d; atn_n = ~atn; eoi_n = ~eoi; dav_n = 1'b1;
    @(negedge clk);
    dav_n = 1'b0;
    @(negedge clk);
    dav_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 listen after reset", listen_flag, 1'b0);
    chk("R10 talk after reset", talk_flag, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][9:2], 1'b1, 1'b0);
      chk($sformatf("R4-vector %0d listen", i), listen_flag, VEC[i][1]);
      chk($sformatf("R6-vector %0d talk", i), talk_flag, VEC[i][0]);
    end

    // R2 my_addr is combinational and gated by ATN
    @(negedge clk);
    bus_d_n = ~8'h0D; atn_n = 1'b0; #1;
    chk("R2 match under ATN", my_addr, 1'b1);
    bus_d_n = ~8'h0C; #1;
    chk("R2 mismatch", my_addr, 1'b0);
    bus_d_n = ~8'h0D; atn_n = 1'b1; #1;
    chk("R2 no ATN", my_addr, 1'b0);

    // R9 EOI asserted: unlisten must be ignored
    send(8'h3F, 1'b1, 1'b1);
    chk("R9 EOI ignored", listen_flag, 1'b1);
    // R9 ATN deasserted: untalk must be ignored
    send(8'h5F, 1'b0, 1'b0);
    chk("R9 no ATN ignored", talk_flag, 1'b1);
    chk("R1 inverted pins, flag held", listen_flag, 1'b1);

    // R3 held DAV does not resample
    @(negedge clk);
    bus_d_n = ~8'h2D; atn_n = 1'b0; eoi_n = 1'b1;
    @(negedge clk); dav_n = 1'b0;
    @(negedge clk); bus_d_n = ~8'h3F;
    repeat (3) @(negedge clk);
    chk("R3 held DAV no resample", listen_flag, 1'b1);
    dav_n = 1'b1;
    @(negedge clk); dav_n = 1'b0;
    @(negedge clk);
    chk("R3 new strobe taken", listen_flag, 1'b0);
    dav_n = 1'b1;

    // R8 listen-only clears a set talk flag and blocks setting it
    chk("R8 talk set before strap", talk_flag, 1'b1);
    @(negedge clk); listen_only = 1'b1;
    @(negedge clk);
    chk("R8 strap clears talk", talk_flag, 1'b0);
    send(8'h4D, 1'b1, 1'b0);
    chk("R8 talk blocked", talk_flag, 1'b0);
    send(8'h2D, 1'b1, 1'b0);
    chk("R8 listen still works", listen_flag, 1'b1);
    @(negedge clk); listen_only = 1'b0;

    // R5 switches all ones: unlisten wins over own listen address
    addr_sw = 5'b11111;
    send(8'h3F, 1'b1, 1'b0);
    chk("R5 unlisten priority", listen_flag, 1'b0);
    send(8'h5F, 1'b1, 1'b0);
    chk("R6 talk at address 31", talk_flag, 1'b1);

    // R10 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R10 talk cleared by reset", talk_flag, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule